// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Set

This block holds the host-visible control registers that steer a bus-master DMA engine with two independent channels. Each channel owns a command byte (start/stop and transfer direction), a status byte (transfer active, error, interrupt and two drive-capable flags) and a 32-bit descriptor table pointer. The host reaches the registers through a simple write port with byte, word and dword sizes, and through a dword-wide read port.

The block turns host activity into commands for the DMA engine. Setting the start/stop bit issues a one-cycle start pulse that carries the channel's descriptor pointer. Clearing it issues a one-cycle abort pulse. The engine reports back through a per-channel completion input and a per-channel error input. Interrupt and error flags are cleared by writing one to them. Each channel drives an interrupt level equal to its interrupt flag.

Top module: `bmdma_regs`

## Requirements
- R1: While a channel's start/stop bit (command bit 0) is set, a command write cannot change the direction bit (command bit 3), which keeps its old value. This includes the write that clears start/stop. When start/stop is clear, the direction bit takes the written value.
- R2: A command write that takes start/stop from 0 to 1 raises that channel's `dma_start_o` for exactly one cycle. In that cycle the channel's slice of `dma_start_ptr_o` holds the current descriptor pointer, and status bit 0 (active) becomes 1.
- R3: A command write that takes start/stop from 1 to 0 raises that channel's `dma_abort_o` for exactly one cycle and clears the active bit. A write that leaves start/stop unchanged produces no pulse.
- R4: Host writes to the status byte never change the active bit (status bit 0). Status bits 7..3 take the written value.
- R5: The error bit (status bit 1) and the interrupt bit (status bit 2) are cleared by writing 1 while they are set. Writing 0 leaves them unchanged, and writing 1 never sets them. A pulse on `dma_err_i` sets the error bit.
- R6: The descriptor pointer is written only by a dword write at channel offset 4. The low two bits are stored as zero. Byte and word writes to offsets 4..7 are ignored.
- R7: A pulse on `dma_done_i` clears that channel's start/stop and active bits and sets its interrupt bit. `irq_o` follows the interrupt bit.
- R8: After reset every register reads zero, except each status byte, which reads 0x60 (drive-capable bits 5 and 6 set).
- R9: The command byte (offset 0) and status byte (offset 2) accept only byte writes. A word or dword write at offset 0 or 2 is ignored. Bytes at offsets 1 and 3 are plain storage written by byte writes.
- R10: Channel c occupies addresses 8*c to 8*c+7. A dword read at offset 0 returns {byte3, status, byte1, command} and a read at offset 4 returns the pointer. The two channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_size | input | 2 | Write size: 0 byte, 1 word, 2 dword |
| wr_data | input | 32 | Write data, right-aligned |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read byte address, dword granular |
| rd_data | output | 32 | Read data |
| dma_done_i | input | NUM_CH | Per-channel transfer completion pulse |
| dma_err_i | input | NUM_CH | Per-channel transfer error pulse |
| dma_start_o | output | NUM_CH | Per-channel start command pulse |
| dma_start_ptr_o | output | 32*NUM_CH | Descriptor pointer sent with the start pulse |
| dma_abort_o | output | NUM_CH | Per-channel abort command pulse |
| irq_o | output | NUM_CH | Per-channel interrupt level |

## Verification
The bench builds the block with two channels, two forced-zero pointer bits and a combinational read path. With these values both channel windows can be reached on a 4-bit address. Pointer alignment can be checked against a value whose low bits are set. Each register write can be read back in the very next cycle. Channel 1 runs a full start, completion and interrupt-clear sequence while channel 0 holds different state, which exposes any crosstalk between the channels.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   typedef enum logic [1:0] {
      XFER_BYTE  = 2'd0,
      XFER_WORD  = 2'd1,
      XFER_DWORD = 2'd2
   } xfer_size_e;

   localparam int CMD_RUN = 0;
   localparam int CMD_DIR = 3;

   localparam int STS_ACT = 0;
   localparam int STS_ERR = 1;
   localparam int STS_IRQ = 2;
   localparam int STS_PLAIN_LO = 3;

   localparam logic [2:0] OFF_CMD   = 3'd0;
   localparam logic [2:0] OFF_AUX0  = 3'd1;
   localparam logic [2:0] OFF_STS   = 3'd2;
   localparam logic [2:0] OFF_AUX1  = 3'd3;
   localparam logic [2:0] OFF_PTR   = 3'd4;

   localparam int CH_SPAN_LOG2 = 3;
   localparam int VIEW_W       = 64;

   typedef struct packed {
      logic        cmd_we;
      logic        sts_we;
      logic        ptr_we;
      logic [1:0]  aux_we;
      logic [31:0] data;
   } chan_wr_t;

endpackage

// File: rtl/bmdma_wr_decode.sv
module bmdma_wr_decode
   import bmdma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [1:0]              wr_size,
   input  logic [31:0]             wr_data,
   output chan_wr_t [NUM_CH-1:0]   wr_o
);

   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [SEL_W-1:0] ch_sel;
   logic [2:0]       off;
   xfer_size_e       size;

   assign off  = wr_addr[2:0];
   assign size = xfer_size_e'(wr_size);

   generate
      if (NUM_CH > 1) begin : g_multi
         assign ch_sel = wr_addr[ADDR_W-1:CH_SPAN_LOG2];
      end else begin : g_single
         assign ch_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         wr_o[c]      = '0;
         wr_o[c].data = wr_data;
         if (wr_en && (ch_sel == SEL_W'(c))) begin
            unique case (size)
               XFER_BYTE: begin
                  unique case (off)
                     OFF_CMD:  wr_o[c].cmd_we    = 1'b1;
                     OFF_AUX0: wr_o[c].aux_we[0] = 1'b1;
                     OFF_STS:  wr_o[c].sts_we    = 1'b1;
                     OFF_AUX1: wr_o[c].aux_we[1] = 1'b1;
                     default:  ;
                  endcase
               end
               XFER_DWORD: begin
                  if (off == OFF_PTR) wr_o[c].ptr_we = 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
#(
   parameter int         PTR_ALIGN = 2,
   parameter logic [7:0] STS_INIT  = 8'h60
) (
   input  logic                clk,
   input  logic                rst_n,
   input  chan_wr_t            wr,
   input  logic                done_i,
   input  logic                err_i,
   output logic                start_o,
   output logic [31:0]         start_ptr_o,
   output logic                abort_o,
   output logic                irq_o,
   output logic [VIEW_W-1:0]   view_o,
   output logic                run_o,
   output logic                dir_o,
   output logic                act_o,
   output logic                err_o
);

   localparam logic [31:0] ALIGN_MASK = (32'd1 << PTR_ALIGN) - 32'd1;

   logic [7:0]  cmd_q, sts_q, aux0_q, aux1_q;
   logic [31:0] ptr_q;
   logic [7:0]  cmd_d, sts_d, cmd_wv;
   logic [31:0] ptr_d;
   logic        go, halt;

   always_comb begin
      cmd_wv = wr.data[7:0];
      if (cmd_q[CMD_RUN]) cmd_wv[CMD_DIR] = cmd_q[CMD_DIR];

      go   = wr.cmd_we & ~cmd_q[CMD_RUN] &  cmd_wv[CMD_RUN];
      halt = wr.cmd_we &  cmd_q[CMD_RUN] & ~cmd_wv[CMD_RUN];

      cmd_d = wr.cmd_we ? cmd_wv : cmd_q;
      if (done_i) cmd_d[CMD_RUN] = 1'b0;

      sts_d = sts_q;
      if (wr.sts_we) begin
         sts_d[7:STS_PLAIN_LO] = wr.data[7:STS_PLAIN_LO];
         sts_d[STS_ERR] = sts_q[STS_ERR] & ~wr.data[STS_ERR];
         sts_d[STS_IRQ] = sts_q[STS_IRQ] & ~wr.data[STS_IRQ];
      end
      if (go)   sts_d[STS_ACT] = 1'b1;
      if (halt) sts_d[STS_ACT] = 1'b0;
      if (err_i) sts_d[STS_ERR] = 1'b1;
      if (done_i) begin
         sts_d[STS_ACT] = 1'b0;
         sts_d[STS_IRQ] = 1'b1;
      end

      ptr_d = wr.ptr_we ? (wr.data & ~ALIGN_MASK) : ptr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q       <= '0;
         sts_q       <= STS_INIT;
         aux0_q      <= '0;
         aux1_q      <= '0;
         ptr_q       <= '0;
         start_o     <= 1'b0;
         abort_o     <= 1'b0;
         start_ptr_o <= '0;
      end else begin
         cmd_q   <= cmd_d;
         sts_q   <= sts_d;
         ptr_q   <= ptr_d;
         start_o <= go;
         abort_o <= halt;
         if (wr.aux_we[0]) aux0_q <= wr.data[7:0];
         if (wr.aux_we[1]) aux1_q <= wr.data[7:0];
         if (go) start_ptr_o <= ptr_q;
      end
   end

   assign irq_o  = sts_q[STS_IRQ];
   assign view_o = {ptr_q, aux1_q, sts_q, aux0_q, cmd_q};
   assign run_o  = cmd_q[CMD_RUN];
   assign dir_o  = cmd_q[CMD_DIR];
   assign act_o  = sts_q[STS_ACT];
   assign err_o  = sts_q[STS_ERR];

endmodule

// File: rtl/bmdma_rd_mux.sv
module bmdma_rd_mux
   import bmdma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic [NUM_CH*VIEW_W-1:0] view_i,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [31:0]              sel_o
);

   localparam int IDX_W  = ADDR_W - 2;
   localparam int N_WORD = NUM_CH * 2;

   logic [IDX_W-1:0] idx;
   assign idx = rd_addr[ADDR_W-1:2];

   always_comb begin
      sel_o = '0;
      for (int w = 0; w < N_WORD; w++) begin
         if (rd_en && (idx == IDX_W'(w))) sel_o = view_i[w*32 +: 32];
      end
   end

   logic unused_lsb;
   assign unused_lsb = ^rd_addr[1:0];

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
#(
   parameter int         NUM_CH    = 2,
   parameter int         PTR_ALIGN = 2,
   parameter logic [1:0] CAP_INIT  = 2'b11,
   parameter bit         RD_REG    = 1'b0,
   localparam int        ADDR_W    = CH_SPAN_LOG2 + $clog2(NUM_CH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [1:0]             wr_size,
   input  logic [31:0]            wr_data,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [31:0]            rd_data,
   input  logic [NUM_CH-1:0]      dma_done_i,
   input  logic [NUM_CH-1:0]      dma_err_i,
   output logic [NUM_CH-1:0]      dma_start_o,
   output logic [NUM_CH*32-1:0]   dma_start_ptr_o,
   output logic [NUM_CH-1:0]      dma_abort_o,
   output logic [NUM_CH-1:0]      irq_o
);

   localparam logic [7:0] STS_INIT = {1'b0, CAP_INIT, 5'b0};

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("bmdma_regs: NUM_CH must lie in 1..4");
      end
      if (PTR_ALIGN < 0 || PTR_ALIGN > 8) begin : g_bad_align
         $error("bmdma_regs: PTR_ALIGN must lie in 0..8");
      end
   endgenerate

   chan_wr_t [NUM_CH-1:0]    wr_vec;
   logic [NUM_CH*VIEW_W-1:0] view_all;
   logic [NUM_CH-1:0]        run_vec, dir_vec, act_vec, err_vec;
   logic [31:0]              rd_sel;

   bmdma_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_size (wr_size),
      .wr_data (wr_data),
      .wr_o    (wr_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      bmdma_chan #(.PTR_ALIGN(PTR_ALIGN), .STS_INIT(STS_INIT)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr          (wr_vec[c]),
         .done_i      (dma_done_i[c]),
         .err_i       (dma_err_i[c]),
         .start_o     (dma_start_o[c]),
         .start_ptr_o (dma_start_ptr_o[c*32 +: 32]),
         .abort_o     (dma_abort_o[c]),
         .irq_o       (irq_o[c]),
         .view_o      (view_all[c*VIEW_W +: VIEW_W]),
         .run_o       (run_vec[c]),
         .dir_o       (dir_vec[c]),
         .act_o       (act_vec[c]),
         .err_o       (err_vec[c])
      );
   end

   bmdma_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
      .view_i  (view_all),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .sel_o   (rd_sel)
   );

   generate
      if (RD_REG) begin : g_rd_flop
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_sel;
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_sel;
      end
   endgenerate

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] dma_done_i,
   input logic [NUM_CH-1:0] dma_err_i,
   input logic [NUM_CH-1:0] dma_start_o,
   input logic [NUM_CH-1:0] dma_abort_o,
   input logic [NUM_CH-1:0] irq_o,
   input logic [NUM_CH-1:0] run_vec,
   input logic [NUM_CH-1:0] dir_vec,
   input logic [NUM_CH-1:0] act_vec,
   input logic [NUM_CH-1:0] err_vec
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_dir_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
         $past(run_vec[c]) |-> (dir_vec[c] == $past(dir_vec[c])));

      assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         dma_start_o[c] |-> !$past(run_vec[c]));

      assert_abort_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
         dma_abort_o[c] |-> ($past(run_vec[c]) && !run_vec[c] && !act_vec[c]));

      assert_active_only_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(act_vec[c]) |-> dma_start_o[c]);

      assert_err_only_on_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(err_vec[c]) |-> $past(dma_err_i[c]));

      assert_done_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
         dma_done_i[c] |=> (!run_vec[c] && !act_vec[c] && irq_o[c]));

      assert_irq_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_o[c]) |-> $past(dma_done_i[c]));
   end

endmodule

bind bmdma_regs bmdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dma_done_i  (dma_done_i),
   .dma_err_i   (dma_err_i),
   .dma_start_o (dma_start_o),
   .dma_abort_o (dma_abort_o),
   .irq_o       (irq_o),
   .run_vec     (run_vec),
   .dir_vec     (dir_vec),
   .act_vec     (act_vec),
   .err_vec     (err_vec)
);

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  dma_done_i = '0;
   logic [1:0]  dma_err_i = '0;
   logic [1:0]  dma_start_o;
   logic [63:0] dma_start_ptr_o;
   logic [1:0]  dma_abort_o;
   logic [1:0]  irq_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bmdma_regs dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_addr         (wr_addr),
      .wr_size         (wr_size),
      .wr_data         (wr_data),
      .rd_en           (rd_en),
      .rd_addr         (rd_addr),
      .rd_data         (rd_data),
      .dma_done_i      (dma_done_i),
      .dma_err_i       (dma_err_i),
      .dma_start_o     (dma_start_o),
      .dma_start_ptr_o (dma_start_ptr_o),
      .dma_abort_o     (dma_abort_o),
      .irq_o           (irq_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // size: 0 byte, 1 word, 2 dword
   task automatic host_wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic host_rd(logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic pulse_done(logic [1:0] m);
      @(negedge clk);
      dma_done_i = m;
      @(negedge clk);
      dma_done_i = '0;
   endtask

   task automatic pulse_err(logic [1:0] m);
      @(negedge clk);
      dma_err_i = m;
      @(negedge clk);
      dma_err_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      host_rd(4'h0, v); check("R8 ch0 ctl", v, 32'h0060_0000);
      host_rd(4'h4, v); check("R8 ch0 ptr", v, 32'h0);
      host_rd(4'h8, v); check("R8 ch1 ctl", v, 32'h0060_0000);
      host_rd(4'hC, v); check("R8 ch1 ptr", v, 32'h0);
      check("R8 pulses/irq", {26'd0, dma_start_o, dma_abort_o, irq_o}, 32'h0);
   endtask

   task automatic t_pointer();
      logic [31:0] v;
      host_wr(4'h4, 2'd2, 32'h1234_567B);
      host_rd(4'h4, v); check("R6 aligned ptr", v, 32'h1234_5678);
      host_wr(4'h4, 2'd0, 32'h0000_00FF);
      host_wr(4'h4, 2'd1, 32'h0000_FFFF);
      host_rd(4'h4, v); check("R6 narrow ptr write ignored", v, 32'h1234_5678);
   endtask

   task automatic t_start_lock_stop();
      logic [31:0] v;
      host_wr(4'h0, 2'd0, 32'h09);
      check("R2 start pulse", {30'd0, dma_start_o}, 32'h1);
      check("R2 start ptr", dma_start_ptr_o[31:0], 32'h1234_5678);
      check("R3 no abort on start", {30'd0, dma_abort_o}, 32'h0);
      @(negedge clk);
      check("R2 pulse one cycle", {30'd0, dma_start_o}, 32'h0);
      host_rd(4'h0, v); check("R2 active set", v, 32'h0061_0009);
      host_wr(4'h0, 2'd0, 32'h01);
      check("R3 no pulse unchanged run", {28'd0, dma_start_o, dma_abort_o}, 32'h0);
      host_rd(4'h0, v); check("R1 dir locked", v, 32'h0061_0009);
      host_wr(4'h2, 2'd0, 32'h60);
      host_rd(4'h0, v); check("R4 active kept while running", v, 32'h0061_0009);
      host_wr(4'h0, 2'd0, 32'h00);
      check("R3 abort pulse", {30'd0, dma_abort_o}, 32'h1);
      @(negedge clk);
      check("R3 abort one cycle", {30'd0, dma_abort_o}, 32'h0);
      host_rd(4'h0, v); check("R1 dir kept on stop, R3 active clear", v, 32'h0060_0008);
      host_wr(4'h0, 2'd0, 32'h00);
      host_rd(4'h0, v); check("R1 dir free when idle", v, 32'h0060_0000);
      host_wr(4'h2, 2'd0, 32'h61);
      host_rd(4'h0, v); check("R4 active not settable", v, 32'h0060_0000);
   endtask

   task automatic t_done_w1c();
      logic [31:0] v;
      host_wr(4'hC, 2'd2, 32'hCAFE_F00D);
      host_rd(4'hC, v); check("R10 ch1 ptr", v, 32'hCAFE_F00C);
      host_wr(4'h8, 2'd0, 32'h01);
      check("R10 ch1 start only", {30'd0, dma_start_o}, 32'h2);
      check("R10 ch1 start ptr", dma_start_ptr_o[63:32], 32'hCAFE_F00C);
      host_rd(4'h8, v); check("R10 ch1 running", v, 32'h0061_0001);
      host_rd(4'h0, v); check("R10 ch0 untouched", v, 32'h0060_0000);
      pulse_done(2'b10);
      host_rd(4'h8, v); check("R7 done effect", v, 32'h0064_0000);
      check("R7 irq level", {30'd0, irq_o}, 32'h2);
      host_wr(4'hA, 2'd0, 32'h60);
      host_rd(4'h8, v); check("R5 write 0 keeps irq", v, 32'h0064_0000);
      host_wr(4'hA, 2'd0, 32'h64);
      host_rd(4'h8, v); check("R5 w1c irq", v, 32'h0060_0000);
      check("R7 irq dropped", {30'd0, irq_o}, 32'h0);
      host_wr(4'hA, 2'd0, 32'h66);
      host_rd(4'h8, v); check("R5 write 1 cannot set", v, 32'h0060_0000);
   endtask

   task automatic t_error();
      logic [31:0] v;
      pulse_err(2'b01);
      host_rd(4'h0, v); check("R5 err input sets", v, 32'h0062_0000);
      host_wr(4'h2, 2'd0, 32'h60);
      host_rd(4'h0, v); check("R5 err kept on 0", v, 32'h0062_0000);
      host_wr(4'h2, 2'd0, 32'h62);
      host_rd(4'h0, v); check("R5 err w1c", v, 32'h0060_0000);
   endtask

   task automatic t_sizes();
      logic [31:0] v;
      host_wr(4'h0, 2'd1, 32'h0000_0001);
      check("R9 word cmd no start", {30'd0, dma_start_o}, 32'h0);
      host_wr(4'h0, 2'd2, 32'h0000_0001);
      check("R9 dword cmd no start", {30'd0, dma_start_o}, 32'h0);
      host_wr(4'h2, 2'd1, 32'h0000_0000);
      host_rd(4'h0, v); check("R9 wide writes ignored", v, 32'h0060_0000);
      host_wr(4'h1, 2'd0, 32'hAB);
      host_wr(4'h3, 2'd0, 32'hCD);
      host_rd(4'h0, v); check("R9 plain bytes", v, 32'hCD60_AB00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pointer();
      t_start_lock_stop();
      t_done_w1c();
      t_error();
      t_sizes();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule